// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog timer for a bus-attached subsystem. A 16-bit counter advances on each pulse of a count-enable input, which stands in for a slow independent clock. A fixed divide-by-256 prescaler can be switched in ahead of the counter to stretch the timeout. When the count reaches the programmed timeout, the block raises a reset request. The request stays high until the block itself is reset.

Software keeps the watchdog alive by writing a two-word refresh key to the key address. In window mode, a refresh that completes too early is treated as a fault. A broken key sequence is also a fault: a wrong second word, a lone second word, or a second word that arrives too late. Each fault raises the reset request at once.

After reset, the configuration can be written once. A write to the control register seals it. Any later change first needs a separate two-word unlock key, which opens the configuration for a fixed number of bus clocks.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `rst_req` is low and the watchdog is enabled, with prescaler off, window mode off, the timeout set to parameter `RST_TIMEOUT` (1000) and the window value set to `RST_WINDOW`. The register addresses are: 0 = key, 1 = control (bit 0 enable, bit 1 prescaler on, bit 2 window mode), 2 = timeout value, 3 = window value.
- R2: While enabled without prescaler, the counter advances by one on every bus clock with `cnt_tick` high. `rst_req` rises one clock after the count is at or above the timeout value.
- R3: With the prescaler on, the counter advances once per 256 `cnt_tick` pulses, so a timeout of N takes about 256·N ticks.
- R4: Writing 0x02A6 and then 0x80B4 to the key address, with the second write at most 16 bus clocks after the first, is a valid refresh. A valid refresh clears both the counter and the prescaler to zero.
- R5: While enabled, a broken refresh sequence raises `rst_req`. This covers a wrong second word after 0x02A6, a 0x80B4 with no 0x02A6 before it, and no second word within 16 bus clocks.
- R6: In window mode, a refresh that completes while the counter is below the window value raises `rst_req`. A refresh at or above the window value is accepted.
- R7: After reset, writes to the timeout and window registers are accepted until the first write to the control register. From then on, configuration writes are ignored.
- R8: Writing 0x20C5 and then 0x28D9 to the key address, at most 16 bus clocks apart, opens the configuration for 128 bus clocks. A control write closes it early. A wrong second unlock word abandons the unlock without raising `rst_req`.
- R9: While disabled, the counter is held at zero, no timeout occurs and broken key sequences do not raise `rst_req`.
- R10: Once high, `rst_req` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_tick | input | 1 | Counter clock enable from the independent time base |
| rst_req | output | 1 | Registered, sticky reset request |

## Verification
The hardest situations to reach are the exact edges of the timing windows. One is a second key word landing on the 16th bus clock after the first, against one landing on the 17th. The other is configuration writes just inside and outside the unlock window. The stimulus places these writes at exact cycle offsets from the first key word or from the unlock. A cycle-accurate reference model then flags any one-cycle slip in `rst_req`. Configuration writes that are ignored are observed through the timeout they fail to shorten.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [DATA_W-1:0] KEY_REF_FIRST  = 16'h02A6;
  localparam logic [DATA_W-1:0] KEY_REF_SECOND = 16'h80B4;
  localparam logic [DATA_W-1:0] KEY_UNL_FIRST  = 16'h20C5;
  localparam logic [DATA_W-1:0] KEY_UNL_SECOND = 16'h28D9;

  localparam logic [ADDR_W-1:0] ADR_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_TOUT = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_WIN  = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REF  = 2'd1,
    SEQ_UNL  = 2'd2
  } seq_e;

  typedef struct packed {
    logic win_mode;
    logic pre_on;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/keyed_wdog_keyseq.sv
module keyed_wdog_keyseq
  import keyed_wdog_pkg::*;
#(
  parameter int KEY_GAP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              refresh_ok,
  output logic              refresh_bad,
  output logic              unlock_ok
);
  localparam int GAP_W = $clog2(KEY_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(KEY_GAP);

  seq_e             state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    state_d     = state_q;
    gap_d       = gap_q;
    refresh_ok  = 1'b0;
    refresh_bad = 1'b0;
    unlock_ok   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (key_wr) begin
          if (key_data == KEY_REF_FIRST) begin
            state_d = SEQ_REF;
            gap_d   = GAP_W'(1);
          end else if (key_data == KEY_UNL_FIRST) begin
            state_d = SEQ_UNL;
            gap_d   = GAP_W'(1);
          end else if (key_data == KEY_REF_SECOND) begin
            refresh_bad = 1'b1;
          end
        end
      end
      SEQ_REF: begin
        if (key_wr) begin
          state_d = SEQ_IDLE;
          if (key_data == KEY_REF_SECOND) refresh_ok = 1'b1;
          else refresh_bad = 1'b1;
        end else if (gap_q == GAP_LAST) begin
          state_d     = SEQ_IDLE;
          refresh_bad = 1'b1;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      SEQ_UNL: begin
        if (key_wr) begin
          state_d = SEQ_IDLE;
          if (key_data == KEY_UNL_SECOND) unlock_ok = 1'b1;
        end else if (gap_q == GAP_LAST) begin
          state_d = SEQ_IDLE;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q != SEQ_IDLE) |-> (gap_q != '0 && gap_q <= GAP_LAST)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({refresh_ok, refresh_bad, unlock_ok}) <= 1); // R5
endmodule

// File: rtl/keyed_wdog_cfg.sv
module keyed_wdog_cfg
  import keyed_wdog_pkg::*;
#(
  parameter int               UNLOCK_CYC  = 128,
  parameter logic [DATA_W-1:0] RST_TIMEOUT = 16'd1000,
  parameter logic [DATA_W-1:0] RST_WINDOW  = 16'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              unlock_ok,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] tout_val,
  output logic [DATA_W-1:0] win_val
);
  localparam int UNL_W = $clog2(UNLOCK_CYC + 1);
  localparam logic [UNL_W-1:0] UNL_LOAD = UNL_W'(UNLOCK_CYC);

  logic             first_open_q;
  logic [UNL_W-1:0] unl_q;
  logic             cfg_open;
  logic             wr_ctrl, wr_tout, wr_win;

  assign cfg_open = first_open_q || (unl_q != '0);
  assign wr_ctrl  = wr_en && cfg_open && (wr_addr == ADR_CTRL);
  assign wr_tout  = wr_en && cfg_open && (wr_addr == ADR_TOUT);
  assign wr_win   = wr_en && cfg_open && (wr_addr == ADR_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_open_q <= 1'b1;
      unl_q        <= '0;
    end else begin
      if (wr_ctrl) first_open_q <= 1'b0;
      if (unlock_ok)          unl_q <= UNL_LOAD;
      else if (wr_ctrl)       unl_q <= '0;
      else if (unl_q != '0)   unl_q <= unl_q - UNL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '{win_mode: 1'b0, pre_on: 1'b0, enable: 1'b1};
      tout_val <= RST_TIMEOUT;
      win_val  <= RST_WINDOW;
    end else begin
      if (wr_ctrl) ctrl     <= ctrl_t'(wr_data[2:0]);
      if (wr_tout) tout_val <= wr_data;
      if (wr_win)  win_val  <= wr_data;
    end
  end

  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> ($stable(tout_val) && $stable(win_val) && $stable(ctrl))); // R7
  AST_UNLOCK_BOUND: assert property (@(posedge clk) disable iff (rst)
    unl_q <= UNL_LOAD); // R8
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (rst)
    unlock_ok |=> cfg_open); // R8
endmodule

// File: rtl/keyed_wdog_counter.sv
module keyed_wdog_counter
  import keyed_wdog_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pre_on,
  input  logic              tick,
  input  logic              clr,
  output logic [DATA_W-1:0] cnt
);
  logic [PRE_W-1:0] pre_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == '1);

  always_ff @(posedge clk) begin
    if (rst || !enable || clr) begin
      pre_q <= '0;
      cnt   <= '0;
    end else if (tick) begin
      if (pre_on) begin
        pre_q <= pre_q + PRE_W'(1);
        if (pre_wrap) cnt <= cnt + DATA_W'(1);
      end else begin
        cnt <= cnt + DATA_W'(1);
      end
    end
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0)); // R9
  AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (rst)
    (enable && pre_on && !clr && tick && !pre_wrap) |=> $stable(cnt)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr && !tick) |=> $stable(cnt)); // R2
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int               KEY_GAP     = 16,
  parameter int               UNLOCK_CYC  = 128,
  parameter int               PRE_W       = 8,
  parameter logic [15:0]      RST_TIMEOUT = 16'd1000,
  parameter logic [15:0]      RST_WINDOW  = 16'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        cnt_tick,
  output logic        rst_req
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] tout_val, win_val, cnt;
  logic              refresh_ok, refresh_bad, unlock_ok;
  logic              early_refresh, seq_fault, tout_fault, clr_cnt;
  logic              rst_req_q;

  keyed_wdog_keyseq #(.KEY_GAP(KEY_GAP)) u_keyseq (
    .clk         (clk),
    .rst         (rst),
    .key_wr      (wr_en && (wr_addr == ADR_KEY)),
    .key_data    (wr_data),
    .refresh_ok  (refresh_ok),
    .refresh_bad (refresh_bad),
    .unlock_ok   (unlock_ok)
  );

  keyed_wdog_cfg #(
    .UNLOCK_CYC  (UNLOCK_CYC),
    .RST_TIMEOUT (RST_TIMEOUT),
    .RST_WINDOW  (RST_WINDOW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .unlock_ok (unlock_ok),
    .ctrl      (ctrl),
    .tout_val  (tout_val),
    .win_val   (win_val)
  );

  assign early_refresh = refresh_ok && ctrl.win_mode && (cnt < win_val);
  assign seq_fault     = ctrl.enable && (refresh_bad || early_refresh);
  assign tout_fault    = ctrl.enable && (cnt >= tout_val);
  assign clr_cnt       = refresh_ok && !early_refresh;

  keyed_wdog_counter #(.PRE_W(PRE_W)) u_counter (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl.enable),
    .pre_on (ctrl.pre_on),
    .tick   (cnt_tick),
    .clr    (clr_cnt),
    .cnt    (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req_q <= 1'b0;
    else     rst_req_q <= rst_req_q || seq_fault || tout_fault;
  end

  assign rst_req = rst_req_q;

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |=> rst_req_q); // R10
  AST_TIMEOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl.enable && (cnt >= tout_val)) |=> rst_req_q); // R2
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrl.enable && refresh_ok && !early_refresh) |=> (cnt == '0)); // R4
  AST_EARLY_FAULT: assert property (@(posedge clk) disable iff (rst)
    (ctrl.enable && early_refresh) |=> rst_req_q); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.enable && !rst_req_q) |=> !rst_req_q); // R9
endmodule

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cnt_tick = 1'b0;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  keyed_wdog dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_tick(cnt_tick), .rst_req(rst_req)
  );

  // Behavioural reference model
  int m_req, m_en, m_pre, m_win, m_to, m_wv, m_cnt, m_ps;
  int m_first, m_unl, m_seq, m_gap;

  always @(posedge clk) begin
    int ok, bad, unl, early, kw;
    if (rst) begin
      m_req = 0; m_en = 1; m_pre = 0; m_win = 0; m_to = 1000; m_wv = 0;
      m_cnt = 0; m_ps = 0; m_first = 1; m_unl = 0; m_seq = 0; m_gap = 0;
    end else begin
      ok = 0; bad = 0; unl = 0;
      kw = (wr_en && wr_addr == 2'd0) ? 1 : 0;
      if (m_seq == 0) begin
        if (kw != 0) begin
          if (wr_data == 16'h02A6) begin m_seq = 1; m_gap = 1; end
          else if (wr_data == 16'h20C5) begin m_seq = 2; m_gap = 1; end
          else if (wr_data == 16'h80B4) bad = 1;
        end
      end else if (kw != 0) begin
        if (m_seq == 1) begin
          if (wr_data == 16'h80B4) ok = 1; else bad = 1;
        end else if (wr_data == 16'h28D9) unl = 1;
        m_seq = 0;
      end else if (m_gap == 16) begin
        if (m_seq == 1) bad = 1;
        m_seq = 0;
      end else m_gap++;
      early = (ok != 0 && m_win != 0 && m_cnt < m_wv) ? 1 : 0;
      if (m_en != 0 && (bad != 0 || early != 0 || m_cnt >= m_to)) m_req = 1;
      // counter
      if (m_en == 0 || (ok != 0 && early == 0)) begin m_cnt = 0; m_ps = 0; end
      else if (cnt_tick) begin
        if (m_pre != 0) begin
          if (m_ps == 255) begin m_ps = 0; m_cnt = (m_cnt + 1) & 16'hFFFF; end
          else m_ps++;
        end else m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      // configuration
      if (wr_en && wr_addr != 2'd0 && (m_first != 0 || m_unl != 0)) begin
        if (wr_addr == 2'd1) begin
          m_en = wr_data[0]; m_pre = wr_data[1]; m_win = wr_data[2];
          m_first = 0;
          if (unl == 0) m_unl = 0;
        end else if (wr_addr == 2'd2) m_to = wr_data;
        else m_wv = wr_data;
      end else if (unl != 0) m_unl = 128;
      else if (m_unl > 0) m_unl--;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rst_req !== (m_req != 0)) begin
        fails++;
        $display("FAIL cycle-compare R2 R5 R6 R10 at %0d: act=%0b exp=%0b", cyc, rst_req, m_req);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired: act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit exp, input string req);
    checks++;
    if (rst_req !== exp) begin
      fails++;
      $display("FAIL %s: rst_req act=%0b exp=%0b", req, rst_req, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cnt_tick = 1'b0; wr_en = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state, default timeout 1000
    do_reset();
    check(1'b0, "R1");
    cnt_tick = 1'b1;
    idle(990);
    check(1'b0, "R1");
    idle(20);
    check(1'b1, "R2");
    idle(20);
    check(1'b1, "R10");

    // R4: refresh clears counter; R2 timeout with programmed value
    do_reset();
    wr(2'd2, 16'd40); wr(2'd1, 16'h0001);
    cnt_tick = 1'b1;
    idle(30);
    wr(2'd0, 16'h02A6); idle(2); wr(2'd0, 16'h80B4);
    idle(30);
    check(1'b0, "R4");
    idle(20);
    check(1'b1, "R2");

    // R5: wrong second word
    do_reset();
    wr(2'd0, 16'h02A6); wr(2'd0, 16'h1234); idle(2);
    check(1'b1, "R5");
    // R5: lone second word
    do_reset();
    wr(2'd0, 16'h80B4); idle(2);
    check(1'b1, "R5");
    // R4: second word exactly 16 clocks after the first
    do_reset();
    wr(2'd0, 16'h02A6); idle(15); wr(2'd0, 16'h80B4); idle(3);
    check(1'b0, "R4");
    // R5: 17 clocks is too late
    do_reset();
    wr(2'd0, 16'h02A6); idle(16); idle(3);
    check(1'b1, "R5");

    // R6: window mode, early and late refresh
    do_reset();
    wr(2'd2, 16'd1000); wr(2'd3, 16'd100); wr(2'd1, 16'h0005);
    cnt_tick = 1'b1; idle(50);
    wr(2'd0, 16'h02A6); wr(2'd0, 16'h80B4); idle(3);
    check(1'b1, "R6");
    do_reset();
    wr(2'd2, 16'd1000); wr(2'd3, 16'd100); wr(2'd1, 16'h0005);
    cnt_tick = 1'b1; idle(150);
    wr(2'd0, 16'h02A6); wr(2'd0, 16'h80B4); idle(3);
    check(1'b0, "R6");
    idle(50);
    check(1'b0, "R6");

    // R3: prescaler, timeout 3 -> about 768 ticks
    do_reset();
    wr(2'd2, 16'd3); wr(2'd1, 16'h0003);
    cnt_tick = 1'b1; idle(700);
    check(1'b0, "R3");
    idle(100);
    check(1'b1, "R3");

    // R7: write after control write is ignored
    do_reset();
    wr(2'd1, 16'h0001); wr(2'd2, 16'd10);
    cnt_tick = 1'b1; idle(100);
    check(1'b0, "R7");

    // R8: unlock then shorten timeout
    do_reset();
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h20C5); wr(2'd0, 16'h28D9); wr(2'd2, 16'd10);
    cnt_tick = 1'b1; idle(20);
    check(1'b1, "R8");
    // R8: unlock window expires after 128 clocks
    do_reset();
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h20C5); wr(2'd0, 16'h28D9); idle(130); wr(2'd2, 16'd10);
    cnt_tick = 1'b1; idle(50);
    check(1'b0, "R8");
    // R8: control write closes the window early
    do_reset();
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h20C5); wr(2'd0, 16'h28D9); wr(2'd1, 16'h0001); wr(2'd2, 16'd10);
    cnt_tick = 1'b1; idle(50);
    check(1'b0, "R8");
    // R8: wrong unlock second word, no reset, still locked
    do_reset();
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h20C5); wr(2'd0, 16'h1111); idle(3);
    check(1'b0, "R8");
    wr(2'd2, 16'd10);
    cnt_tick = 1'b1; idle(50);
    check(1'b0, "R8");

    // R9: disabled watchdog
    do_reset();
    wr(2'd2, 16'd5); wr(2'd1, 16'h0000);
    cnt_tick = 1'b1; idle(100);
    check(1'b0, "R9");
    wr(2'd0, 16'h80B4); idle(3);
    check(1'b0, "R9");
    wr(2'd0, 16'h02A6); idle(20);
    check(1'b0, "R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule